// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds both strobes inactive for a power-up pause. It then runs a train of wake-up cycles. From that point on it produces refresh cycles at a steady rate, so that every row is covered within the retention period. Each refresh uses the CAS-before-RAS method: column strobe low first, then row strobe low. The DRAM supplies the row from its own counter, so the block drives no address, data, write-enable or output-enable. All timing values are given in nanoseconds together with the clock period. They are turned into cycle counts at elaboration. Strobe timings and the pause are rounded up. The refresh interval is rounded down.

The block shares the strobes with an access controller through a request/grant pair. It raises `refReq` when it needs a refresh cycle. It starts the cycle only after it sees `refGnt` while its own request is visible, and it keeps the request high until the precharge that closes the cycle has ended. While grants are withheld, interval ticks pile up in a backlog counter. The backlog is repaid with back-to-back cycles once the grant returns. If a tick arrives while the backlog is already at its limit, the retention deadline counts as missed. `initDone` then drops and the wake-up train is run again, without a second pause. The access controller must accept no host traffic while `initDone` is low.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is asserted, `rasN` and `casN` are 1, and `refReq` and `initDone` are 0.
- R2: After reset is released, `refReq`, `rasN` and `casN` stay inactive for at least ceil(PAUSE_NS/CLK_NS) cycles.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles are issued before `initDone` goes to 1. Both strobes are high in the cycle in which it rises.
- R4: Every refresh follows the CAS-before-RAS order. `casN` falls only while `rasN` is 1. It stays 0 for exactly ceil(CAS_LEAD_NS/CLK_NS) cycles before `rasN` falls, and it is still 0 in the cycle in which `rasN` falls.
- R5: `rasN` stays 0 for exactly ceil(RAS_LOW_NS/CLK_NS) cycles. During that time `casN` stays 0 for exactly ceil(CAS_HOLD_NS/CLK_NS) cycles. Both strobes are 1 for at least ceil(PRECHARGE_NS/CLK_NS) cycles before `casN` falls again.
- R6: A strobe is driven low only while `refReq` is 1. A refresh begins only after `refGnt` is seen with `refReq` high. While `refGnt` is held low, no refresh cycle occurs.
- R7: Once `initDone` is 1 and grants are immediate, one refresh is issued every floor(floor(RETENTION_NS/ROWS)/CLK_NS) cycles.
- R8: Interval ticks that arrive while grants are withheld are counted, up to BACKLOG_LIMIT. When the grant returns they are repaid with back-to-back refresh cycles, and `initDone` stays 1.
- R9: A tick that arrives with the backlog at BACKLOG_LIMIT drops `initDone`. It rises again only after WAKE_CYCLES further refresh cycles, and no new power-up pause is inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| refGnt | input | 1 | Access controller hands the strobes to the sequencer |
| refReq | output | 1 | Sequencer wants, or holds, the strobes for a refresh |
| rasN | output | 1 | Row strobe, active low, registered |
| casN | output | 1 | Column strobe, active low, registered |
| initDone | output | 1 | Wake-up train complete; normal access is allowed |

## Verification
The interval tick and the completion of a catch-up refresh can land in the same cycle. They must leave the backlog unchanged, and they must not be read as a missed deadline. The bench provokes this by withholding the grant until the backlog has filled to its limit. It then releases the grant just before the next tick, so that tick lands while the repayment cycles are still draining the backlog. The result is judged at the ports: `initDone` must stay high, and the repayment must show up as back-to-back refresh cycles. A longer withholding then shows the opposite case, where the tick finds the backlog full and the wake-up train must run again.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_REQ,
    S_CASLEAD,
    S_RASLOW,
    S_PRECH
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reqOn;
    logic casLow;
    logic rasLow;
    logic phaseClr;
    logic cycleDone;
  } seqCmd_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int minOf(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import refseq_pkg::*;
#(
  parameter int PAUSE_C = 20000,
  parameter int CSR_C   = 1,
  parameter int CHR_C   = 1,
  parameter int RAS_C   = 5,
  parameter int PRE_C   = 3,
  parameter int PH_W    = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            refGnt,
  input  logic            refReqQ,
  input  logic            rasN,
  input  logic            initDone,
  input  logic            pendingNz,
  input  logic [PH_W-1:0] phaseCnt,
  output seqCmd_t         cmd
);

  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_PAUSE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      S_PAUSE: begin
        if (phaseCnt == PH_W'(PAUSE_C - 1)) begin
          nextState    = S_IDLE;
          cmd.phaseClr = 1'b1;
        end
      end
      S_IDLE: begin
        if (!initDone || pendingNz) nextState = S_REQ;
      end
      S_REQ: begin
        cmd.reqOn = 1'b1;
        if (refReqQ && refGnt) begin
          nextState    = S_CASLEAD;
          cmd.phaseClr = 1'b1;
        end
      end
      S_CASLEAD: begin
        cmd.reqOn  = 1'b1;
        cmd.casLow = 1'b1;
        if (phaseCnt == PH_W'(CSR_C - 1)) begin
          nextState    = S_RASLOW;
          cmd.phaseClr = 1'b1;
        end
      end
      S_RASLOW: begin
        cmd.reqOn  = 1'b1;
        cmd.rasLow = 1'b1;
        cmd.casLow = (phaseCnt < PH_W'(CHR_C));
        if (phaseCnt == PH_W'(RAS_C - 1)) begin
          nextState    = S_PRECH;
          cmd.phaseClr = 1'b1;
        end
      end
      S_PRECH: begin
        cmd.reqOn = 1'b1;
        if (phaseCnt == PH_W'(PRE_C - 1)) begin
          nextState     = S_IDLE;
          cmd.phaseClr  = 1'b1;
          cmd.cycleDone = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R4: row strobe must still be inactive while the column strobe leads
  assert_ras_high_in_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CASLEAD) |-> rasN);

  // R2: nothing requested before the pause has elapsed
  assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAUSE) |-> (!refReqQ && rasN));

endmodule

// File: rtl/refseq_dp.sv
module refseq_dp
  import refseq_pkg::*;
#(
  parameter int INT_C     = 1562,
  parameter int WAKE_N    = 8,
  parameter int BACKLOG_N = 4,
  parameter int PH_W      = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seqCmd_t         cmd,
  output logic [PH_W-1:0] phaseCnt,
  output logic            pendingNz,
  output logic            initDone,
  output logic            refReq,
  output logic            rasN,
  output logic            casN
);

  localparam int TIM_W  = $clog2(INT_C + 1);
  localparam int WAKE_W = $clog2(WAKE_N + 1);
  localparam int PEND_W = $clog2(BACKLOG_N + 1);

  logic [TIM_W-1:0]  timer;
  logic [WAKE_W-1:0] wakeLeft;
  logic [PEND_W-1:0] pendCnt;
  logic              tick, doneNormal, lapse, pendFull, pendDec;

  assign tick       = initDone && (timer == TIM_W'(INT_C - 1));
  assign doneNormal = cmd.cycleDone && initDone;
  assign pendFull   = (pendCnt == PEND_W'(BACKLOG_N));
  assign pendDec    = doneNormal && (pendCnt != '0);
  assign lapse      = tick && pendFull && !pendDec;
  assign pendingNz  = (pendCnt != '0);

  // strobes and request are registered straight from the command
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseCnt <= '0;
      rasN     <= 1'b1;
      casN     <= 1'b1;
      refReq   <= 1'b0;
    end else begin
      phaseCnt <= cmd.phaseClr ? '0 : phaseCnt + 1'b1;
      rasN     <= ~cmd.rasLow;
      casN     <= ~cmd.casLow;
      refReq   <= cmd.reqOn;
    end
  end

  // interval timer, backlog and wake-up bookkeeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer    <= '0;
      wakeLeft <= WAKE_W'(WAKE_N);
      pendCnt  <= '0;
      initDone <= 1'b0;
    end else if (lapse) begin
      timer    <= '0;
      wakeLeft <= WAKE_W'(WAKE_N);
      pendCnt  <= '0;
      initDone <= 1'b0;
    end else if (!initDone) begin
      timer <= '0;
      if (cmd.cycleDone) begin
        wakeLeft <= wakeLeft - 1'b1;
        if (wakeLeft == WAKE_W'(1)) initDone <= 1'b1;
      end
    end else begin
      timer <= tick ? '0 : timer + 1'b1;
      unique case ({tick, pendDec})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // R4: row strobe falls only with the column strobe already and still low
  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> (!casN && $past(!casN)));

  // R6: strobes are driven only while the request is held
  assert_strobe_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rasN || !casN) |-> refReq);

  // R8: backlog never exceeds its limit
  assert_backlog_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pendCnt <= PEND_W'(BACKLOG_N));

  // R3: ready is announced only between cycles
  assert_init_rise_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(initDone) |-> (rasN && casN));

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refseq_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int PAUSE_NS      = 200000,
  parameter int RETENTION_NS  = 32000000,
  parameter int ROWS          = 2048,
  parameter int CAS_LEAD_NS   = 5,
  parameter int CAS_HOLD_NS   = 8,
  parameter int RAS_LOW_NS    = 50,
  parameter int PRECHARGE_NS  = 30,
  parameter int WAKE_CYCLES   = 8,
  parameter int BACKLOG_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refGnt,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic initDone
);

  localparam int PAUSE_C = maxOf(1, ceilDiv(PAUSE_NS, CLK_NS));
  localparam int CSR_C   = maxOf(1, ceilDiv(CAS_LEAD_NS, CLK_NS));
  localparam int RAS_C   = maxOf(1, ceilDiv(RAS_LOW_NS, CLK_NS));
  localparam int CHR_C   = minOf(RAS_C, maxOf(1, ceilDiv(CAS_HOLD_NS, CLK_NS)));
  localparam int PRE_C   = maxOf(1, ceilDiv(PRECHARGE_NS, CLK_NS));
  localparam int INT_C   = maxOf(2, (RETENTION_NS / ROWS) / CLK_NS);
  localparam int PH_MAX  = maxOf(maxOf(PAUSE_C, RAS_C), maxOf(CSR_C, PRE_C));
  localparam int PH_W    = $clog2(PH_MAX + 1);

  seqCmd_t         cmd;
  logic [PH_W-1:0] phaseCnt;
  logic            pendingNz;

  refseq_ctrl #(
    .PAUSE_C(PAUSE_C), .CSR_C(CSR_C), .CHR_C(CHR_C),
    .RAS_C(RAS_C), .PRE_C(PRE_C), .PH_W(PH_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .refGnt(refGnt), .refReqQ(refReq),
    .rasN(rasN), .initDone(initDone), .pendingNz(pendingNz),
    .phaseCnt(phaseCnt), .cmd(cmd)
  );

  refseq_dp #(
    .INT_C(INT_C), .WAKE_N(WAKE_CYCLES), .BACKLOG_N(BACKLOG_LIMIT), .PH_W(PH_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .phaseCnt(phaseCnt),
    .pendingNz(pendingNz), .initDone(initDone), .refReq(refReq),
    .rasN(rasN), .casN(casN)
  );

endmodule

// File: tb/refresh_sequencer_tb.sv
module refresh_sequencer_tb;

  localparam int EXP_PAUSE = (1000 + 9) / 10;
  localparam int EXP_INT   = (3250 / 8) / 10;
  localparam int EXP_CSR   = (15 + 9) / 10;
  localparam int EXP_CHR   = (11 + 9) / 10;
  localparam int EXP_RAS   = (45 + 9) / 10;
  localparam int EXP_PRE   = (30 + 9) / 10;
  localparam int EXP_WAKE  = 4;
  localparam int EXP_BACK  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refGnt = 1'b1;
  logic refReq, rasN, casN, initDone;

  int checks = 0;
  int fails = 0;
  int cbrCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  refresh_sequencer #(
    .CLK_NS(10), .PAUSE_NS(1000), .RETENTION_NS(3250), .ROWS(8),
    .CAS_LEAD_NS(15), .CAS_HOLD_NS(11), .RAS_LOW_NS(45), .PRECHARGE_NS(30),
    .WAKE_CYCLES(EXP_WAKE), .BACKLOG_LIMIT(EXP_BACK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .refGnt(refGnt), .refReq(refReq),
    .rasN(rasN), .casN(casN), .initDone(initDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // strobe monitor, sampled on the falling clock edge
  logic prevRas = 1'b1, prevCas = 1'b1;
  int leadRun = 0, rasRun = 0, holdRun = 0, highRun = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prevRas && !rasN) begin
        cbrCount++;
        check(!casN && leadRun == EXP_CSR, "R4 cas lead before ras fall", leadRun, EXP_CSR);
      end
      if (prevCas && !casN) begin
        check(rasN == 1'b1, "R4 cas falls with ras high", rasN, 1);
        check(refReq && refGnt, "R6 strobes only when granted", refReq, 1);
        if (cbrCount > 0)
          check(highRun >= EXP_PRE, "R5 precharge length", highRun, EXP_PRE);
        highRun = 0;
      end
      if (rasN && !casN) leadRun++;
      else if (casN) leadRun = 0;
      if (!rasN) begin
        rasRun++;
        if (!casN) holdRun++;
      end
      if (!prevRas && rasN) begin
        check(rasRun == EXP_RAS, "R5 ras low width", rasRun, EXP_RAS);
        check(holdRun == EXP_CHR, "R5 cas hold after ras fall", holdRun, EXP_CHR);
        rasRun = 0;
        holdRun = 0;
      end
      if (rasN && casN) highRun++;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic waitInitRise(input int maxc, output int used);
    used = 0;
    while (!initDone && used < maxc) begin
      cyc(1);
      used++;
    end
  endtask

  task automatic syncAfterRefresh();
    int guard = 0;
    while (rasN && guard < 200) begin cyc(1); guard++; end
    while (!rasN && guard < 400) begin cyc(1); guard++; end
    cyc(EXP_PRE + 2);
  endtask

  initial begin
    int n, base, used;
    bit stayed;
    cyc(3);
    // R1: reset state
    check(rasN == 1'b1, "R1 rasN in reset", rasN, 1);
    check(casN == 1'b1, "R1 casN in reset", casN, 1);
    check(refReq == 1'b0, "R1 refReq in reset", refReq, 0);
    check(initDone == 1'b0, "R1 initDone in reset", initDone, 0);
    rst_n = 1'b1;

    // R2: quiet pause
    n = 0;
    while (!refReq && n < EXP_PAUSE + 50) begin cyc(1); n++; end
    check(n >= EXP_PAUSE && n <= EXP_PAUSE + 4, "R2 pause length", n, EXP_PAUSE);
    check(cbrCount == 0, "R2 no refresh during pause", cbrCount, 0);

    // R3: wake-up train
    waitInitRise(1000, used);
    check(initDone && cbrCount == EXP_WAKE, "R3 wake cycles before ready", cbrCount, EXP_WAKE);

    // R7: steady refresh rate
    base = cbrCount;
    cyc(10 * EXP_INT + 20);
    check(cbrCount - base == 10, "R7 refreshes in ten intervals", cbrCount - base, 10);

    // R8: backlog filled to the limit, then repaid
    syncAfterRefresh();
    refGnt = 1'b0;
    base = cbrCount;
    stayed = 1'b1;
    repeat (3 * EXP_INT + 5) begin cyc(1); if (!initDone) stayed = 1'b0; end
    check(cbrCount == base, "R6 no refresh while grant withheld", cbrCount - base, 0);
    check(refReq == 1'b1, "R6 request held while waiting", refReq, 1);
    refGnt = 1'b1;
    repeat (50) begin cyc(1); if (!initDone) stayed = 1'b0; end
    check(cbrCount - base >= EXP_BACK, "R8 catch-up cycles", cbrCount - base, EXP_BACK);
    check(stayed, "R8 ready kept through backlog", stayed, 1);

    // R9: deadline missed, wake-up repeated without pause
    syncAfterRefresh();
    refGnt = 1'b0;
    base = cbrCount;
    cyc(6 * EXP_INT);
    check(initDone == 1'b0, "R9 ready dropped on lapse", initDone, 0);
    check(cbrCount == base, "R6 no refresh during lapse", cbrCount - base, 0);
    refGnt = 1'b1;
    base = cbrCount;
    waitInitRise(1000, used);
    check(initDone && cbrCount - base == EXP_WAKE, "R9 wake cycles repeated", cbrCount - base, EXP_WAKE);
    check(used <= EXP_WAKE * (EXP_CSR + EXP_RAS + EXP_PRE + 3) + 8, "R9 no second pause",
          used, EXP_WAKE * (EXP_CSR + EXP_RAS + EXP_PRE + 3) + 8);

    // R7: rate resumes after re-init
    base = cbrCount;
    cyc(3 * EXP_INT + 20);
    check(cbrCount - base == 3, "R7 rate after re-init", cbrCount - base, 3);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule